// File: doc/BRIEF.md
# I2C Master Byte-Transfer Controller

This block is a single-master I2C engine that software runs one byte at a time. Software writes a byte into the data buffer, sets the level controls `start_i`, `stop_i` and `acknak_i`, then pulses `go_set`. The engine may first issue a START, or a repeated START when it already holds the bus. It then moves the byte MSB first and handles the acknowledge bit. It may finish with a STOP. If no STOP was asked for, the engine parks with SCL pulled low until the next go. This lets software take as long as it needs between bytes without losing the bus.

The byte sent with a START is the 7-bit target address followed by the direction bit. That bit selects transmit (0) or receive (1) for the bytes that follow. SCL and SDA are open drain. The engine only drives the enables `scl_oe` and `sda_oe`, where 1 pulls the line low, and it reads the wired line levels back. A line monitor tracks START and STOP conditions to report whether the bus is busy. The SCL period is a parameter counted in system clocks.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both line enables are 0 (lines released), `go`=0, `tx_empty`=1, `rx_full`=0, `nak_seen`=0, `arb_lost`=0 and `busy`=0.
- R2: With `start_i`=1, a go from the idle bus issues a START (SDA falls while SCL is high). It then sends the buffer MSB first as address[7:1] plus direction bit[0].
- R3: When the direction bit is 0, the following bytes are transmitted MSB first. The acknowledge bit of every transmitted byte, address included, is read from the slave, and a high level (NAK) sets `nak_seen`.
- R4: When the direction bit is 1, the following bytes are received MSB first into the buffer (`buf_rdata`) and `rx_full` is set. The master drives the acknowledge bit low when `acknak_i`=0 and leaves it released (NAK) when `acknak_i`=1.
- R5: When a byte finishes, `go` returns to 0 and `tx_empty` becomes 1. A buffer write clears `tx_empty`.
- R6: After a byte and its acknowledge bit without STOP, SCL stays low until software sets go again.
- R7: A go with `start_i`=1 while the engine holds the bus issues a repeated START with no STOP in between, followed by the new address byte from the buffer.
- R8: A go with `stop_i`=1 (any `start_i`) moves the byte and its acknowledge bit and then issues a STOP (SDA rises while SCL is high). Both lines are then released and `busy` drops.
- R9: A go with `start_i`=0 and `stop_i`=0 moves one byte with no START or STOP around it.
- R10: If the bus is busy or SDA is low when a START is requested, `arb_lost` is set and no line is driven. The START is retried once the bus becomes free. `arb_lost` stays set until the next go.
- R11: `busy` rises after any START seen on the lines and falls after any STOP, whichever master caused them.
- R12: The engine changes SDA only while SCL is low, except for its own START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_wr | input | 1 | Write strobe for the data buffer |
| buf_wdata | input | 8 | Byte written into the buffer |
| go_set | input | 1 | Pulse that sets the go bit |
| start_i | input | 1 | Level: issue START or repeated START before the byte |
| stop_i | input | 1 | Level: issue STOP after the byte |
| acknak_i | input | 1 | Level: in receive, 1 sends NAK, 0 sends ACK |
| scl_in | input | 1 | Wired SCL level |
| sda_in | input | 1 | Wired SDA level |
| buf_rdata | output | 8 | Buffer contents (received byte after a read) |
| go | output | 1 | Go bit, cleared by the engine at byte end |
| tx_empty | output | 1 | Byte finished, buffer free |
| rx_full | output | 1 | A received byte is in the buffer |
| nak_seen | output | 1 | Slave answered the last transmitted byte with NAK |
| busy | output | 1 | Bus busy from START/STOP monitoring |
| arb_lost | output | 1 | START request found the bus taken |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench puts a behavioural slave and a second master on the wired lines and counts every START, repeated START and STOP they see. An engine that moves SDA in the middle of a high SCL phase shows up as an extra condition, and one that forgets a repeated START or STOP shows up as a missing one. A read ends with a NAK byte. Confusing the `acknak_i` polarity, or shifting LSB first, gives the slave the wrong acknowledge or the wrong buffer value. The bench holds the bus with a foreign START when a START is requested. An engine that ignores the busy state would drive the lines or miss `arb_lost`, and one that never retries leaves `go` stuck. The bench also watches SCL through the wait between bytes, because an engine that does not stretch would let it rise.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_WAITFREE, S_ST_A, S_RS_A, S_RS_B, S_ST_B, S_ST_C,
    S_BIT, S_HOLD, S_SP_A, S_SP_B, S_SP_C
  } eng_state_e;
endpackage

// File: rtl/i2cm_tick.sv
// Free-running quarter-period strobe for the SCL timing.
module i2cm_tick #(
  parameter int SCL_PERIOD = 40
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int QTR = SCL_PERIOD / 4;
  localparam int CW  = (QTR > 1) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(QTR - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  assert_cnt_range_R12: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(QTR));
endmodule

// File: rtl/i2cm_busmon.sv
// Registers the wired lines and tracks bus ownership from START/STOP.
module i2cm_busmon (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic busy
);
  logic sda_p;
  logic start_det, stop_det;

  assign start_det = scl_s & sda_p & ~sda_s;
  assign stop_det  = scl_s & ~sda_p & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s <= 1'b1;
      sda_s <= 1'b1;
      sda_p <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_s <= scl_in;
      sda_s <= sda_in;
      sda_p <= sda_s;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  assert_start_sets_busy_R11: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);
  assert_stop_clears_busy_R11: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);
endmodule

// File: rtl/i2cm_engine.sv
// Byte sequencer: START/repeated START, 8 bits + acknowledge, STOP, hold.
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              buf_wr,
  input  logic [BYTE_W-1:0] buf_wdata,
  input  logic              go_set,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              acknak_i,
  input  logic              bus_busy,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              go_q,
  output logic [BYTE_W-1:0] buf_q,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              nak_seen,
  output logic              arb_lost,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam logic [3:0] ACK_IDX = 4'(BYTE_W);

  eng_state_e        st;
  logic [1:0]        q;
  logic [3:0]        bidx;
  logic [BYTE_W-1:0] sr;
  logic              is_addr, rd_mode, stop_lat;
  logic              scl_d, sda_d;
  logic              bit_tx;

  assign bit_tx = is_addr | ~rd_mode;

  // Line drive per state; SDA in a bit cell is only recomputed in quarter 0.
  always_comb begin
    scl_d = 1'b0;
    sda_d = 1'b0;
    unique case (st)
      S_RS_A:  scl_d = 1'b1;
      S_ST_B:  sda_d = 1'b1;
      S_ST_C:  begin scl_d = 1'b1; sda_d = 1'b1; end
      S_BIT: begin
        scl_d = (q < 2'd2);
        if (q != 2'd0)          sda_d = sda_oe;
        else if (bidx == ACK_IDX) sda_d = ~bit_tx & ~acknak_i;
        else                    sda_d = bit_tx & ~sr[BYTE_W-1];
      end
      S_HOLD:  scl_d = 1'b1;
      S_SP_A:  begin scl_d = 1'b1; sda_d = 1'b1; end
      S_SP_B:  sda_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; q <= '0; bidx <= '0; sr <= '0;
      is_addr <= 1'b0; rd_mode <= 1'b0; stop_lat <= 1'b0;
      go_q <= 1'b0; buf_q <= '0; tx_empty <= 1'b1; rx_full <= 1'b0;
      nak_seen <= 1'b0; arb_lost <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      scl_oe <= scl_d;
      sda_oe <= sda_d;
      if (buf_wr) begin
        buf_q    <= buf_wdata;
        tx_empty <= 1'b0;
      end
      if (go_set) begin
        go_q     <= 1'b1;
        arb_lost <= 1'b0;
        nak_seen <= 1'b0;
        rx_full  <= 1'b0;
      end
      if (tick) begin
        unique case (st)
          S_IDLE: if (go_q) begin
            if (start_i) begin
              if (bus_busy | ~sda_s | ~scl_s) begin
                arb_lost <= 1'b1;
                st       <= S_WAITFREE;
              end else st <= S_ST_A;
            end else begin
              sr <= buf_q; is_addr <= 1'b0; stop_lat <= stop_i;
              q <= '0; bidx <= '0; st <= S_BIT;
            end
          end
          S_WAITFREE: if (!bus_busy) st <= S_IDLE;
          S_ST_A:  st <= S_ST_B;
          S_RS_A:  st <= S_RS_B;
          S_RS_B:  st <= S_ST_B;
          S_ST_B:  st <= S_ST_C;
          S_ST_C: begin
            sr <= buf_q; is_addr <= 1'b1; rd_mode <= buf_q[0];
            stop_lat <= stop_i; q <= '0; bidx <= '0; st <= S_BIT;
          end
          S_HOLD: if (go_q) begin
            if (start_i) st <= S_RS_A;
            else begin
              sr <= buf_q; is_addr <= 1'b0; stop_lat <= stop_i;
              q <= '0; bidx <= '0; st <= S_BIT;
            end
          end
          S_BIT: begin
            q <= q + 2'd1;
            if (q == 2'd2) begin
              if (bidx != ACK_IDX) sr <= {sr[BYTE_W-2:0], sda_s};
              else if (bit_tx)     nak_seen <= sda_s;
            end
            if (q == 2'd3) begin
              if (bidx == ACK_IDX) begin
                if (!bit_tx) begin
                  buf_q   <= sr;
                  rx_full <= 1'b1;
                end
                if (stop_lat) st <= S_SP_A;
                else begin
                  st       <= S_HOLD;
                  go_q     <= 1'b0;
                  tx_empty <= 1'b1;
                end
              end else bidx <= bidx + 4'd1;
            end
          end
          S_SP_A:  st <= S_SP_B;
          S_SP_B:  st <= S_SP_C;
          S_SP_C: begin
            st       <= S_IDLE;
            go_q     <= 1'b0;
            tx_empty <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // SDA may not move during a released SCL inside a bit cell.
  assert_sda_stable_scl_high_R12: assert property (@(posedge clk) disable iff (rst)
    (st == S_BIT && $past(st == S_BIT) && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));
  assert_hold_keeps_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && $past(st == S_HOLD)) |-> scl_oe);
  assert_busy_start_flags_arb_R10: assert property (@(posedge clk) disable iff (rst)
    (tick && st == S_IDLE && go_q && start_i && bus_busy) |=> arb_lost);
  assert_done_clears_go_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_empty) && !$past(buf_wr)) |-> !go_q);
  assert_stop_end_clears_go_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && st == S_SP_C && !go_set) |=> (!go_q && !scl_oe && !sda_oe));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int SCL_PERIOD = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_wr,
  input  logic [BYTE_W-1:0] buf_wdata,
  input  logic              go_set,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              acknak_i,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic [BYTE_W-1:0] buf_rdata,
  output logic              go,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              nak_seen,
  output logic              busy,
  output logic              arb_lost,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic tick, scl_s, sda_s;

  i2cm_tick #(.SCL_PERIOD(SCL_PERIOD)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  i2cm_busmon u_mon (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .busy(busy)
  );

  i2cm_engine u_eng (
    .clk(clk), .rst(rst), .tick(tick),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .go_set(go_set),
    .start_i(start_i), .stop_i(stop_i), .acknak_i(acknak_i),
    .bus_busy(busy), .scl_s(scl_s), .sda_s(sda_s),
    .go_q(go), .buf_q(buf_rdata), .tx_empty(tx_empty), .rx_full(rx_full),
    .nak_seen(nak_seen), .arb_lost(arb_lost), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       buf_wr = 0, go_set = 0, start_i = 0, stop_i = 0, acknak_i = 0;
  logic [7:0] buf_wdata = 0;
  logic [7:0] buf_rdata;
  logic go, tx_empty, rx_full, nak_seen, busy, arb_lost, scl_oe, sda_oe;
  logic sl_sda = 0, om_sda = 0;

  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | sl_sda | om_sda);

  i2c_byte_master u0 (
    .clk(clk), .rst(rst), .buf_wr(buf_wr), .buf_wdata(buf_wdata), .go_set(go_set),
    .start_i(start_i), .stop_i(stop_i), .acknak_i(acknak_i),
    .scl_in(scl_l), .sda_in(sda_l), .buf_rdata(buf_rdata), .go(go),
    .tx_empty(tx_empty), .rx_full(rx_full), .nak_seen(nak_seen), .busy(busy),
    .arb_lost(arb_lost), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural slave plus line-condition counters and busy model.
  int sbit = 0, sstate = 0, n_start = 0, n_rstart = 0, n_stop = 0, mis = 0, busy_fail = 0;
  logic [7:0] ssr = 0, rdb = 0;
  logic srd = 0, amatch = 0, m_ack = 0, p_scl = 1, p_sda = 1, busy_m = 0;
  logic [7:0] got_addr[$], got_data[$], rd_q[$];

  always @(negedge clk) begin
    if (rst) begin
      sbit = 0; sstate = 0; sl_sda = 0; busy_m = 0; p_scl = 1; p_sda = 1;
    end else begin
      if (p_scl && scl_l && p_sda && !sda_l) begin
        n_start++; if (busy_m) n_rstart++;
        busy_m = 1; sbit = 0; sstate = 1; sl_sda = 0;
      end else if (p_scl && scl_l && !p_sda && sda_l) begin
        n_stop++; busy_m = 0; sstate = 0; sl_sda = 0;
      end else if (!p_scl && scl_l && sstate != 0) begin
        if (sbit < 8) ssr = {ssr[6:0], sda_l}; else m_ack = sda_l;
        sbit++;
      end else if (p_scl && !scl_l && sstate != 0) begin
        if (sbit == 8) begin
          if (sstate == 1) begin
            got_addr.push_back(ssr);
            amatch = (ssr[7:1] == SLV); srd = ssr[0]; sl_sda = amatch;
          end else if (sstate == 2) begin
            got_data.push_back(ssr); sl_sda = (ssr != 8'hEE);
          end else sl_sda = 0;
        end else if (sbit == 9) begin
          sbit = 0;
          if (sstate == 1) sstate = amatch ? (srd ? 3 : 2) : 0;
          else if (sstate == 3 && m_ack) sstate = 0;
          if (sstate == 3) begin rdb = rd_q.pop_front(); sl_sda = ~rdb[7]; end
          else sl_sda = 0;
        end else if (sstate == 3 && sbit >= 1 && sbit <= 7) sl_sda = ~rdb[7-sbit];
      end
      p_scl = scl_l; p_sda = sda_l;
      if (busy != busy_m) mis++; else mis = 0;
      if (mis == 4) busy_fail++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic put_byte(input logic [7:0] d, input logic s, input logic p, input logic a);
    @(negedge clk); buf_wdata = d; buf_wr = 1; start_i = s; stop_i = p; acknak_i = a;
    @(negedge clk); buf_wr = 0; go_set = 1;
    @(negedge clk); go_set = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (go && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, tag, n, 20000);
    repeat (50) @(negedge clk);
  endtask

  int e_start = 0, e_stop = 0, low_cnt;

  initial begin
    rd_q.push_back(8'hA7); rd_q.push_back(8'h19); rd_q.push_back(8'h6E);
    repeat (5) @(negedge clk);
    chk(!scl_oe && !sda_oe && !go && tx_empty && !rx_full && !nak_seen && !arb_lost && !busy,
        "R1 reset state", {scl_oe, sda_oe, go, tx_empty, rx_full, nak_seen, arb_lost, busy}, 8'h10);
    rst = 0;
    repeat (20) @(negedge clk);

    // Write transfer: address, plain byte, final byte with STOP.
    put_byte(8'hB4, 1, 0, 0);
    chk(tx_empty == 0, "R5 buffer write clears tx_empty", tx_empty, 0);
    wait_done("R2 address byte finish");
    e_start++;
    chk(got_addr.size() == 1 && got_addr[0] == 8'hB4, "R2 address seen by slave", got_addr[$], 8'hB4);
    chk(!go && tx_empty, "R5 go cleared and tx_empty set", {go, tx_empty}, 2'b01);
    chk(!nak_seen, "R3 address acked", nak_seen, 0);
    chk(busy, "R11 busy after START", busy, 1);
    low_cnt = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!scl_l) low_cnt++; end
    chk(low_cnt == 200, "R6 SCL held low between bytes", low_cnt, 200);

    put_byte(8'h3C, 0, 0, 0);
    wait_done("R9 plain byte finish");
    chk(got_data.size() == 1 && got_data[0] == 8'h3C, "R9 plain data byte", got_data[$], 8'h3C);
    chk(n_start == e_start && n_stop == e_stop, "R9 no START or STOP around byte", n_start*16 + n_stop, e_start*16 + e_stop);

    put_byte(8'hEE, 0, 1, 0);
    wait_done("R8 stop byte finish");
    e_stop++;
    chk(got_data[$] == 8'hEE, "R3 transmitted byte MSB first", got_data[$], 8'hEE);
    chk(nak_seen, "R3 slave NAK reported", nak_seen, 1);
    chk(n_stop == e_stop, "R8 STOP issued", n_stop, e_stop);
    chk(!busy && scl_l && sda_l, "R8 bus released after STOP", {busy, scl_l, sda_l}, 3'b011);

    // Read transfer: address with R/nW=1, ACKed byte, NAKed byte with STOP.
    put_byte(8'hB5, 1, 0, 0);
    wait_done("R4 read address finish");
    e_start++;
    put_byte(8'h00, 0, 0, 0);
    wait_done("R4 read byte finish");
    chk(buf_rdata == 8'hA7 && rx_full, "R4 received byte in buffer", buf_rdata, 8'hA7);
    chk(m_ack == 0, "R4 master ACK with acknak=0", m_ack, 0);
    put_byte(8'h00, 0, 1, 1);
    wait_done("R4 last read finish");
    e_stop++;
    chk(buf_rdata == 8'h19, "R4 second received byte", buf_rdata, 8'h19);
    chk(m_ack == 1, "R4 master NAK with acknak=1", m_ack, 1);
    chk(n_start == e_start && n_stop == e_stop, "R12 read conditions count", n_start*16 + n_stop, e_start*16 + e_stop);

    // Repeated START to change direction.
    put_byte(8'hB4, 1, 0, 0); wait_done("R7 first address");
    put_byte(8'h55, 0, 0, 0); wait_done("R7 data");
    put_byte(8'hB5, 1, 0, 0); wait_done("R7 repeated address");
    e_start += 2;
    chk(n_rstart == 1 && n_stop == e_stop, "R7 repeated START without STOP", n_rstart, 1);
    chk(got_addr[$] == 8'hB5 && busy, "R7 new address after repeated START", got_addr[$], 8'hB5);
    put_byte(8'h00, 0, 1, 1); wait_done("R7 read after repeat");
    e_stop++;
    chk(buf_rdata == 8'h6E, "R7 read after repeated START", buf_rdata, 8'h6E);

    // Arbitration: another master holds the bus.
    @(negedge clk); om_sda = 1;
    repeat (5) @(negedge clk);
    e_start++;
    chk(busy, "R11 busy from foreign START", busy, 1);
    put_byte(8'hB4, 1, 0, 0);
    repeat (300) @(negedge clk);
    chk(arb_lost && go, "R10 arbitration lost flagged", {arb_lost, go}, 2'b11);
    chk(!scl_oe && !sda_oe, "R10 no drive while bus taken", {scl_oe, sda_oe}, 0);
    om_sda = 0;
    e_stop++;
    wait_done("R10 retry finish");
    e_start++;
    chk(got_addr[$] == 8'hB4 && !nak_seen, "R10 START retried after bus free", got_addr[$], 8'hB4);
    put_byte(8'h01, 0, 1, 0); wait_done("R10 closing byte");
    e_stop++;
    chk(got_data[$] == 8'h01 && !arb_lost, "R10 transfer after retry", got_data[$], 8'h01);
    chk(n_start == e_start && n_stop == e_stop, "R12 total START/STOP count", n_start*256 + n_stop, e_start*256 + e_stop);
    chk(busy_fail == 0, "R11 busy tracks line model every clock", busy_fail, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule